// File: doc/BRIEF.md
# Two-Wire Serial Memory Write Controller

This block is the receiving half of a byte-addressed serial memory that sits on a two-wire bus (clock line and open-drain data line). A fast system clock samples both lines. The block finds Start and Stop conditions and decodes three kinds of byte: a device selection byte, a word address byte, and any number of data bytes. It acknowledges each byte by driving an open-drain enable on the data line.

Data bytes go into a 16-entry page buffer first. The buffer is written into the 128-byte internal array only when the master closes the frame with a Stop in the slot right after a data byte's acknowledge. A programming timer then holds a busy output high for a fixed number of system cycles. While the timer runs, the block stays silent on the bus.

A write-lock input refuses data bytes but still lets the selection and address phases complete. The bus master cannot read the array; it is exposed through a combinational inspection port, and the committed address counter is an output.

Top module: `serial_mem_wr`

## Requirements
- R1: After reset, sda_oe and busy are low, addr_ptr is 0 and every array byte reads 0 on the inspection port.
- R2: A selection byte is acknowledged only when bits 7:4 equal 1010, bits 3:1 equal the DEV_SEL parameter and bit 0 (direction) is 0. Any other selection byte, a read request included, is NACKed, and no later byte is acknowledged until the next Start.
- R3: The byte after an accepted selection is the word address and is always acknowledged; its low 7 bits load the write pointer. The bytes that follow are data and are acknowledged while wr_lock is low.
- R4: The array changes only on a Stop in the slot that directly follows an acknowledged data byte. A Stop in the middle of a byte, or a Stop right after the address byte, writes nothing and leaves busy low.
- R5: Data byte k (counting from 0) of a frame with word address a is stored at page base (a with bits 3:0 cleared) plus ((a + k) mod 16). Both single-byte and multi-byte frames are supported, and a later byte in the same slot replaces an earlier one.
- R6: After a commit, busy is high for exactly PROG_CYCLES system cycles. During that time nothing is acknowledged, not even a matching selection byte.
- R7: After a commit, addr_ptr equals page base plus ((a + n) mod 16), where n is the number of data bytes accepted. A frame that does not commit leaves addr_ptr unchanged.
- R8: With wr_lock high, the selection and address bytes are still acknowledged, every data byte is NACKed, and a Stop in the post-acknowledge slot changes neither the array nor addr_ptr and raises no busy.
- R9: A repeated Start discards the pending page data. Only the bytes of the frame that the repeated Start opens can be committed.
- R10: sda_oe changes only while the synchronized clock line is low, and it is never high while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired result) |
| wr_lock | input | 1 | High refuses data bytes and blocks writes |
| sda_oe | output | 1 | High pulls the data line low (acknowledge) |
| busy | output | 1 | High while the programming timer runs |
| peek_addr | input | 7 | Array inspection address |
| peek_data | output | 8 | Array byte at peek_addr |
| addr_ptr | output | 7 | Committed internal address counter |

## Verification
The clock-edge checks on sda_oe assume that the bus clock stays low for more than the two-flop synchronizer delay plus one cycle, and that the master never issues a Start or Stop while the block is driving an acknowledge. The bench's bit-banged master holds each bus phase for four system cycles, so a low clock period lasts eight cycles. It changes the data line only while the clock is low, except when it forms a Start or a Stop, and it always releases the data line during the acknowledge slot. wr_lock is treated as quasi-static: the bench changes it only between frames.

// File: rtl/serial_mem_pkg.sv
`timescale 1ns/1ps
package serial_mem_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_DEV   = 2'd1,
    PH_WADDR = 2'd2,
    PH_DATA  = 2'd3
  } phase_e;

  localparam logic [3:0] SEL_CODE = 4'b1010;
  localparam int unsigned BYTE_BITS = 8;
endpackage

// File: rtl/sm_line_sync.sv
`timescale 1ns/1ps
module sm_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] scl_sh_q, sda_sh_q, scl_sh_d, sda_sh_d;
  logic       scl_old_q, sda_old_q;

  always_comb begin
    scl_sh_d = {scl_sh_q[0], scl_i};
    sda_sh_d = {sda_sh_q[0], sda_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh_q  <= 2'b11;
      sda_sh_q  <= 2'b11;
      scl_old_q <= 1'b1;
      sda_old_q <= 1'b1;
    end else begin
      scl_sh_q  <= scl_sh_d;
      sda_sh_q  <= sda_sh_d;
      scl_old_q <= scl_sh_q[1];
      sda_old_q <= sda_sh_q[1];
    end
  end

  always_comb begin
    scl_lvl   = scl_sh_q[1];
    sda_lvl   = sda_sh_q[1];
    scl_rise  = scl_lvl & ~scl_old_q;
    scl_fall  = ~scl_lvl & scl_old_q;
    start_det = scl_lvl & scl_old_q & sda_old_q & ~sda_lvl;
    stop_det  = scl_lvl & scl_old_q & ~sda_old_q & sda_lvl;
  end
endmodule

// File: rtl/sm_frame_fsm.sv
`timescale 1ns/1ps
module sm_frame_fsm
  import serial_mem_pkg::*;
#(
  parameter int          AW      = 7,
  parameter int          PW      = 4,
  parameter logic [2:0]  DEV_SEL = 3'b000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_lvl,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          wr_lock,
  input  logic          busy,
  output logic          sda_oe,
  output logic          commit,
  output logic          buf_clear,
  output logic          buf_we,
  output logic [PW-1:0] buf_idx,
  output logic [7:0]    buf_data,
  output logic [AW-1:0] ptr
);
  localparam logic [3:0] LAST_BIT = 4'd7;
  localparam logic [3:0] ACK_BIT  = 4'd8;

  phase_e        phase_q, phase_d;
  logic [3:0]    bit_q, bit_d;
  logic [7:0]    sh_q, sh_d;
  logic          ackph_q, ackph_d;
  logic          acksel_q, acksel_d;
  logic          oe_q, oe_d;
  logic          slot_q, slot_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic [7:0]    byte_v;
  logic          sel_hit;

  always_comb begin
    byte_v  = {sh_q[6:0], sda_lvl};
    sel_hit = (byte_v[7:4] == SEL_CODE) && (byte_v[3:1] == DEV_SEL) && !byte_v[0];
  end

  always_comb begin
    phase_d   = phase_q;
    bit_d     = bit_q;
    sh_d      = sh_q;
    ackph_d   = ackph_q;
    acksel_d  = acksel_q;
    oe_d      = oe_q;
    slot_d    = slot_q;
    ptr_d     = ptr_q;
    commit    = 1'b0;
    buf_clear = 1'b0;
    buf_we    = 1'b0;
    buf_idx   = ptr_q[PW-1:0];
    buf_data  = byte_v;
    if (busy) begin
      phase_d = PH_IDLE;
      bit_d   = '0;
      ackph_d = 1'b0;
      oe_d    = 1'b0;
      slot_d  = 1'b0;
    end else if (start_det) begin
      phase_d = PH_DEV;
      bit_d   = '0;
      ackph_d = 1'b0;
      oe_d    = 1'b0;
      slot_d  = 1'b0;
    end else if (stop_det) begin
      commit  = (phase_q == PH_DATA) && slot_q;
      phase_d = PH_IDLE;
      bit_d   = '0;
      ackph_d = 1'b0;
      oe_d    = 1'b0;
      slot_d  = 1'b0;
    end else if (phase_q != PH_IDLE) begin
      if (scl_rise && !ackph_q && (bit_q != ACK_BIT)) begin
        sh_d  = byte_v;
        bit_d = bit_q + 4'd1;
        if (bit_q == 4'd1) begin
          slot_d = 1'b0;
        end
        if (bit_q == LAST_BIT) begin
          unique case (phase_q)
            PH_DEV:   acksel_d = sel_hit;
            PH_WADDR: begin
              acksel_d  = 1'b1;
              ptr_d     = byte_v[AW-1:0];
              buf_clear = 1'b1;
            end
            PH_DATA: begin
              acksel_d = !wr_lock;
              if (!wr_lock) begin
                buf_we = 1'b1;
                ptr_d  = {ptr_q[AW-1:PW], ptr_q[PW-1:0] + 1'b1};
              end
            end
            default: acksel_d = 1'b0;
          endcase
        end
      end else if (scl_fall) begin
        if (ackph_q) begin
          ackph_d = 1'b0;
          oe_d    = 1'b0;
          bit_d   = '0;
          unique case (phase_q)
            PH_DEV:   phase_d = acksel_q ? PH_WADDR : PH_IDLE;
            PH_WADDR: phase_d = PH_DATA;
            PH_DATA:  slot_d  = acksel_q;
            default:  phase_d = PH_IDLE;
          endcase
        end else if (bit_q == ACK_BIT) begin
          ackph_d = 1'b1;
          oe_d    = acksel_q;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      bit_q    <= '0;
      sh_q     <= '0;
      ackph_q  <= 1'b0;
      acksel_q <= 1'b0;
      oe_q     <= 1'b0;
      slot_q   <= 1'b0;
      ptr_q    <= '0;
    end else begin
      phase_q  <= phase_d;
      bit_q    <= bit_d;
      sh_q     <= sh_d;
      ackph_q  <= ackph_d;
      acksel_q <= acksel_d;
      oe_q     <= oe_d;
      slot_q   <= slot_d;
      ptr_q    <= ptr_d;
    end
  end

  assign sda_oe = oe_q;
  assign ptr    = ptr_q;
endmodule

// File: rtl/sm_page_store.sv
`timescale 1ns/1ps
module sm_page_store #(
  parameter int MEM_BYTES  = 128,
  parameter int PAGE_BYTES = 16,
  localparam int AW = $clog2(MEM_BYTES),
  localparam int PW = $clog2(PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          buf_clear,
  input  logic          buf_we,
  input  logic [PW-1:0] buf_idx,
  input  logic [7:0]    buf_data,
  input  logic          commit,
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] peek_addr,
  output logic [7:0]    peek_data,
  output logic [AW-1:0] addr_ptr
);
  localparam int GW = AW - PW;

  logic [PAGE_BYTES*8-1:0] pbuf;
  logic [PAGE_BYTES-1:0]   pvalid;
  logic [MEM_BYTES*8-1:0]  mem_flat;
  logic [AW-1:0]           aptr_q, aptr_d;

  for (genvar e = 0; e < PAGE_BYTES; e++) begin : g_page
    logic [7:0] d_q, d_d;
    logic       v_q, v_d;
    logic       we_e;
    always_comb begin
      we_e = buf_we && (buf_idx == PW'(e));
      d_d  = we_e ? buf_data : d_q;
      v_d  = buf_clear ? 1'b0 : (we_e ? 1'b1 : v_q);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d_q <= '0;
        v_q <= 1'b0;
      end else begin
        d_q <= d_d;
        v_q <= v_d;
      end
    end
    assign pbuf[e*8 +: 8] = d_q;
    assign pvalid[e]      = v_q;
  end

  for (genvar g = 0; g < MEM_BYTES; g++) begin : g_cell
    localparam logic [PW-1:0] SLOT = PW'(g % PAGE_BYTES);
    localparam logic [GW-1:0] PAGE = GW'(g / PAGE_BYTES);
    logic [7:0] c_q;
    logic       hit;
    always_comb begin
      hit = commit && (ptr[AW-1:PW] == PAGE) && pvalid[SLOT];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        c_q <= '0;
      end else if (hit) begin
        c_q <= pbuf[SLOT*8 +: 8];
      end
    end
    assign mem_flat[g*8 +: 8] = c_q;
  end

  always_comb begin
    aptr_d = commit ? ptr : aptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aptr_q <= '0;
    end else begin
      aptr_q <= aptr_d;
    end
  end

  assign addr_ptr  = aptr_q;
  assign peek_data = mem_flat[peek_addr*8 +: 8];
endmodule

// File: rtl/sm_prog_timer.sv
`timescale 1ns/1ps
module sm_prog_timer #(
  parameter int PROG_CYCLES = 5000,
  localparam int CW = $clog2(PROG_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (start) begin
      cnt_d = CW'(PROG_CYCLES);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/serial_mem_wr.sv
`timescale 1ns/1ps
module serial_mem_wr #(
  parameter logic [2:0] DEV_SEL     = 3'b000,
  parameter int         MEM_BYTES   = 128,
  parameter int         PAGE_BYTES  = 16,
  parameter int         PROG_CYCLES = 5000,
  localparam int        AW = $clog2(MEM_BYTES),
  localparam int        PW = $clog2(PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          wr_lock,
  output logic          sda_oe,
  output logic          busy,
  input  logic [AW-1:0] peek_addr,
  output logic [7:0]    peek_data,
  output logic [AW-1:0] addr_ptr
);
  logic [1:0]    rst_sh_q;
  logic          arst_n;
  logic          scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic          commit, buf_clear, buf_we;
  logic [PW-1:0] buf_idx;
  logic [7:0]    buf_data;
  logic [AW-1:0] ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sh_q <= 2'b00;
    end else begin
      rst_sh_q <= {rst_sh_q[0], 1'b1};
    end
  end
  assign arst_n = rst_sh_q[1];

  sm_line_sync u_sync (
    .clk       (clk),
    .rst_n     (arst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  sm_frame_fsm #(.AW(AW), .PW(PW), .DEV_SEL(DEV_SEL)) u_fsm (
    .clk       (clk),
    .rst_n     (arst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_lvl   (sda_lvl),
    .start_det (start_det),
    .stop_det  (stop_det),
    .wr_lock   (wr_lock),
    .busy      (busy),
    .sda_oe    (sda_oe),
    .commit    (commit),
    .buf_clear (buf_clear),
    .buf_we    (buf_we),
    .buf_idx   (buf_idx),
    .buf_data  (buf_data),
    .ptr       (ptr)
  );

  sm_page_store #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_store (
    .clk       (clk),
    .rst_n     (arst_n),
    .buf_clear (buf_clear),
    .buf_we    (buf_we),
    .buf_idx   (buf_idx),
    .buf_data  (buf_data),
    .commit    (commit),
    .ptr       (ptr),
    .peek_addr (peek_addr),
    .peek_data (peek_data),
    .addr_ptr  (addr_ptr)
  );

  sm_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (arst_n),
    .start (commit),
    .busy  (busy)
  );
endmodule

// File: rtl/sm_wr_checker.sv
`timescale 1ns/1ps
module sm_wr_checker #(
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sda_oe,
  input logic          busy,
  input logic          scl_lvl,
  input logic          commit,
  input logic [AW-1:0] addr_ptr
);
  p_quiet_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);

  p_oe_rise_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_lvl);

  p_oe_fall_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> !scl_lvl);

  p_commit_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> busy);

  p_no_commit_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !commit);

  p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(addr_ptr));
endmodule

bind serial_mem_wr sm_wr_checker #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (arst_n),
  .sda_oe   (sda_oe),
  .busy     (busy),
  .scl_lvl  (scl_lvl),
  .commit   (commit),
  .addr_ptr (addr_ptr)
);

// File: tb/sim_serial_mem_wr.sv
`timescale 1ns/1ps
module sim_serial_mem_wr;
  localparam int         Q    = 4;
  localparam int         PROG = 600;
  localparam logic [2:0] SEL  = 3'b101;

  logic       clk;
  logic       rst_n;
  logic       m_scl, m_sda;
  logic       wr_lock;
  logic       sda_oe, busy;
  logic [6:0] peek_addr, addr_ptr;
  logic [7:0] peek_data;
  logic       sda_line;

  int   n_checks, n_fails;
  int   busy_cnt, busy_last, busy_runs, oe_bad;
  logic oe_prev;
  logic [7:0] model [128];
  logic [6:0] mptr;

  assign sda_line = m_sda & ~sda_oe;

  serial_mem_wr #(.DEV_SEL(SEL), .PROG_CYCLES(PROG)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (m_scl),
    .sda_i     (sda_line),
    .wr_lock   (wr_lock),
    .sda_oe    (sda_oe),
    .busy      (busy),
    .peek_addr (peek_addr),
    .peek_data (peek_data),
    .addr_ptr  (addr_ptr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // busy run length and R10 monitor, sampled away from the active edge
  initial begin
    busy_cnt = 0; busy_last = 0; busy_runs = 0; oe_bad = 0; oe_prev = 1'b0;
    forever begin
      @(negedge clk);
      if (busy) busy_cnt++;
      else if (busy_cnt != 0) begin
        busy_last = busy_cnt; busy_runs++; busy_cnt = 0;
      end
      if (rst_n && (sda_oe !== oe_prev) && m_scl) oe_bad++;
      if (busy && sda_oe) oe_bad++;
      oe_prev = sda_oe;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cond_start();
    m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(Q);
    m_sda = 1'b0; wt(Q); m_scl = 1'b0; wt(Q);
  endtask

  task automatic cond_stop();
    m_sda = 1'b0; wt(Q); m_scl = 1'b1; wt(Q);
    m_sda = 1'b1; wt(2*Q);
  endtask

  task automatic send_bits(input int n);
    for (int i = 0; i < n; i++) begin
      m_sda = 1'($urandom); wt(Q); m_scl = 1'b1; wt(2*Q); m_scl = 1'b0; wt(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wt(Q); m_scl = 1'b1; wt(2*Q); m_scl = 1'b0; wt(Q);
    end
    m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(Q);
    ack = (sda_line == 1'b0);
    wt(Q); m_scl = 1'b0; wt(Q);
  endtask

  task automatic chk_mem(input string req);
    int bad; int first;
    bad = 0; first = -1;
    for (int a = 0; a < 128; a++) begin
      peek_addr = 7'(a);
      #0.1;
      if (peek_data !== model[a]) begin
        bad++;
        if (first < 0) first = a;
      end
    end
    if (first < 0) chk(1'b1, req, 0, 0);
    else begin
      peek_addr = 7'(first); #0.1;
      chk(1'b0, req, int'(peek_data), int'(model[first]));
    end
  endtask

  // one frame: ending 0 stop in slot, 1 stop mid-byte, 2 restart+stop,
  // 3 restart + one-byte write at 0x48
  task automatic txn(input logic [2:0] sel, input bit rw, input logic [7:0] wa,
                     input int n, input bit lock, input int ending, input bit probe);
    bit ack, expd, commit_exp;
    logic [7:0] d;
    logic [7:0] pb [16];
    bit         pv [16];
    logic [6:0] p;
    int         runs0;
    wr_lock = lock;
    runs0 = busy_runs;
    cond_start();
    send_byte({4'b1010, sel, rw}, ack);
    expd = (sel == SEL) && !rw;
    chk(ack == expd, "R2 select ack", int'(ack), int'(expd));
    if (!expd) begin
      send_byte(wa, ack);
      chk(ack == 1'b0, "R2 ignored after nack", int'(ack), 0);
      cond_stop();
      chk(busy == 1'b0, "R2 no busy", int'(busy), 0);
      chk(addr_ptr == mptr, "R7 ptr kept", int'(addr_ptr), int'(mptr));
      chk_mem("R2 array kept");
      wr_lock = 1'b0;
      return;
    end
    send_byte(wa, ack);
    chk(ack == 1'b1, "R3 address ack", int'(ack), 1);
    p = wa[6:0];
    for (int i = 0; i < 16; i++) pv[i] = 1'b0;
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      send_byte(d, ack);
      if (lock) chk(ack == 1'b0, "R8 data nack", int'(ack), 0);
      else      chk(ack == 1'b1, "R3 data ack", int'(ack), 1);
      if (!lock) begin
        pb[p[3:0]] = d; pv[p[3:0]] = 1'b1;
        p = {p[6:4], p[3:0] + 4'd1};
      end
    end
    commit_exp = 1'b0;
    case (ending)
      0: begin cond_stop(); commit_exp = (n > 0) && !lock; end
      1: begin send_bits(3); cond_stop(); end
      2: begin cond_start(); cond_stop(); end
      default: begin
        wr_lock = 1'b0;
        cond_start();
        send_byte({4'b1010, SEL, 1'b0}, ack);
        chk(ack == 1'b1, "R9 restart select", int'(ack), 1);
        send_byte(8'h48, ack);
        chk(ack == 1'b1, "R9 restart address", int'(ack), 1);
        send_byte(8'h5A, ack);
        chk(ack == 1'b1, "R9 restart data", int'(ack), 1);
        cond_stop();
        for (int i = 0; i < 16; i++) pv[i] = 1'b0;
        pb[8] = 8'h5A; pv[8] = 1'b1; p = 7'h49;
        commit_exp = 1'b1;
      end
    endcase
    if (commit_exp) begin
      for (int i = 0; i < 16; i++)
        if (pv[i]) model[{p[6:4], 4'(i)}] = pb[i];
      mptr = p;
    end
    if (probe && commit_exp) begin
      cond_start();
      send_byte({4'b1010, SEL, 1'b0}, ack);
      chk(ack == 1'b0, "R6 silent while busy", int'(ack), 0);
      cond_stop();
    end
    if (commit_exp) begin
      while (busy) @(negedge clk);
      wt(2);
      chk(busy_runs == runs0 + 1 && busy_last == PROG, "R6 busy length", busy_last, PROG);
    end else begin
      chk(busy == 1'b0 && busy_runs == runs0, "R4 no busy without commit", int'(busy), 0);
    end
    chk(addr_ptr == mptr, "R7 address counter", int'(addr_ptr), int'(mptr));
    chk_mem(commit_exp ? "R5 array content" : "R4 array unchanged");
    wr_lock = 1'b0;
  endtask

  initial begin
    int r;
    n_checks = 0; n_fails = 0;
    void'($urandom(32'd977));
    m_scl = 1'b1; m_sda = 1'b1; wr_lock = 1'b0; peek_addr = '0;
    for (int a = 0; a < 128; a++) model[a] = 8'h00;
    mptr = '0;
    rst_n = 1'b0;
    wt(5);
    rst_n = 1'b1;
    wt(5);
    chk(sda_oe == 1'b0, "R1 sda_oe reset", int'(sda_oe), 0);
    chk(busy == 1'b0, "R1 busy reset", int'(busy), 0);
    chk(addr_ptr == 7'd0, "R1 ptr reset", int'(addr_ptr), 0);
    chk_mem("R1 array reset");
    // R5 single byte, then page write that wraps inside its page
    txn(SEL, 1'b0, 8'h05, 1, 1'b0, 0, 1'b0);
    txn(SEL, 1'b0, 8'h3C, 6, 1'b0, 0, 1'b0);
    // R5 more than a page: overwrite inside the same page
    txn(SEL, 1'b0, 8'h72, 19, 1'b0, 0, 1'b0);
    // R6 probe during programming
    txn(SEL, 1'b0, 8'h10, 2, 1'b0, 0, 1'b1);
    // R8 locked frame
    txn(SEL, 1'b0, 8'h20, 3, 1'b1, 0, 1'b0);
    // R2 wrong select and read request
    txn(3'b011, 1'b0, 8'h20, 2, 1'b0, 0, 1'b0);
    txn(SEL, 1'b1, 8'h20, 2, 1'b0, 0, 1'b0);
    // R4 stop mid-byte and stop after address only
    txn(SEL, 1'b0, 8'h30, 2, 1'b0, 1, 1'b0);
    txn(SEL, 1'b0, 8'h30, 0, 1'b0, 0, 1'b0);
    // R9 repeated start discards pending bytes
    txn(SEL, 1'b0, 8'h20, 3, 1'b0, 2, 1'b0);
    txn(SEL, 1'b0, 8'h24, 4, 1'b0, 3, 1'b0);
    // constrained random frames
    for (int t = 0; t < 20; t++) begin
      logic [2:0] s;
      r = int'($urandom % 10);
      s = ($urandom % 8 == 0) ? 3'($urandom) : SEL;
      txn(s, ($urandom % 10 == 0), 8'($urandom), 1 + int'($urandom % 18),
          ($urandom % 5 == 0), (r < 7) ? 0 : ((r < 9) ? 1 : 2), 1'b0);
    end
    chk(oe_bad == 0, "R10 drive only with clock low and never while busy", oe_bad, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule